// File: doc/BRIEF.md
# Bus-Master DMA Channel Register Set

This block holds the software-visible control state of one bus-master DMA channel for an ATA-style disk controller. A processor reaches it through a simple byte-addressed register port with an 8-byte window. The window holds a command byte, a status byte and a 32-bit pointer to the physical region descriptor table. The DMA engine itself sits outside the block. The block talks to it only through a one-cycle start request, a one-cycle abort request, the descriptor pointer and a one-cycle completion strobe.

Writing the go bit of the command byte controls a transfer. Changing go from 0 to 1 launches a transfer from the current pointer. Changing it from 1 to 0 aborts the transfer. When the engine finishes, it pulses the completion strobe. The channel then returns to idle and raises its interrupt flag, which drives the interrupt request pin. Software acknowledges the interrupt by writing 1 to the flag.

The register port is a plain strobe interface with no back-pressure. Every access completes in the cycle it is presented. Read data is combinational from the address and size, and a write takes effect at the next clock edge. Only one access is presented per cycle.

Top module: `bmdma_chan_regs`

## Requirements
- R1: After reset the command byte and the pointer read 0, the status byte reads 0x60, irq is 0 and dma_start, dma_abort and acc_size_err are 0.
- R2: A read uses acc_size 0 for a byte, 1 for a half-word and 2 for a word, and size code 3 reads 0. It returns, little-endian, the bytes from acc_addr upward of the image {pointer[31:0], 8'h00, status, 8'h00, command}, with command at offset 0, status at 2 and the pointer at 4. Bytes past offset 7 and the reserved offsets 1 and 3 read 0.
- R3: The command (offset 0) and status (offset 2) bytes accept only size-0 writes, and the pointer (offset 4) accepts only size-2 writes. A write to one of these offsets at any other size changes nothing, and acc_size_err is high for exactly the next cycle.
- R4: A command write that changes go (bit 0) from 0 to 1 sets active (status bit 0). In the next cycle it drives dma_start high for one cycle, while dma_desc_ptr carries the stored pointer.
- R5: A command write that changes go from 1 to 0 clears active and drives dma_abort high for one cycle in the next cycle.
- R6: A command write that leaves go unchanged issues neither dma_start nor dma_abort.
- R7: The direction bit (command bit 3) takes the written value only while go is 0. While go is 1 it keeps its value. Other command bits read 0.
- R8: Active is read-only: a status write never changes it.
- R9: Status bit 2 (interrupt) and bit 1 (error) are cleared by writing 1 while they are 1. Writing 0, or writing 1 while they are 0, leaves them unchanged. Bits 5 and 6 are plain read/write, and bits 3, 4 and 7 read 0.
- R10: A pointer write stores the data with bits 1:0 forced to 0.
- R11: A dma_done pulse clears go and active and sets the interrupt bit.
- R12: irq equals the interrupt bit. When dma_done coincides with a write of 1 to the interrupt bit, the bit stays set.
- R13: A command write in the same cycle as dma_done is ignored and issues no start or abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Register access presented this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 3 | Byte offset in the channel window |
| acc_size | input | 2 | 0 byte, 1 half-word, 2 word |
| acc_wdata | input | 32 | Write data, least significant byte at acc_addr |
| acc_rdata | output | 32 | Read data for the presented address and size |
| acc_size_err | output | 1 | One-cycle flag after a write of illegal size |
| dma_start | output | 1 | One-cycle transfer launch request |
| dma_abort | output | 1 | One-cycle transfer abort request |
| dma_desc_ptr | output | 32 | Descriptor table pointer for the engine |
| dma_done | input | 1 | One-cycle completion strobe from the engine |
| irq | output | 1 | Interrupt request, follows the interrupt bit |

## Verification
The completion strobe can land in the same cycle as a software write. Two such collisions matter: completion against a write of 1 to the interrupt bit, and completion against a command write that would start or abort a transfer. The bench drives dma_done and the write in the same cycle for each case. A behavioural reference model then judges the outcome every clock. The interrupt bit must stay set, and no start or abort pulse may appear. Afterwards a read of the status and command bytes confirms the stored state.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;
  localparam logic [ADDR_W-1:0] OFF_CMD  = 3'd0;
  localparam logic [ADDR_W-1:0] OFF_STAT = 3'd2;
  localparam logic [ADDR_W-1:0] OFF_PTR  = 3'd4;

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2, SZ_NONE = 2'd3} acc_size_e;

  localparam int CMD_GO  = 0;
  localparam int CMD_DIR = 3;
  localparam int ST_ACT  = 0;
  localparam int ST_ERR  = 1;
  localparam int ST_INT  = 2;
  localparam int ST_CAPL = 5;
  localparam int ST_CAPH = 6;
endpackage

// File: rtl/bmdma_decode.sv
module bmdma_decode
  import bmdma_pkg::*;
(
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_size,
  output logic              wr_cmd,
  output logic              wr_stat,
  output logic              wr_ptr,
  output logic              size_bad
);
  logic wr, hit_cmd, hit_stat, hit_ptr, is_byte, is_word;

  always_comb begin
    wr       = acc_valid && acc_write;
    hit_cmd  = wr && (acc_addr == OFF_CMD);
    hit_stat = wr && (acc_addr == OFF_STAT);
    hit_ptr  = wr && (acc_addr == OFF_PTR);
    is_byte  = (acc_size == SZ_BYTE);
    is_word  = (acc_size == SZ_WORD);
    wr_cmd   = hit_cmd && is_byte;
    wr_stat  = hit_stat && is_byte;
    wr_ptr   = hit_ptr && is_word;
    size_bad = ((hit_cmd || hit_stat) && !is_byte) || (hit_ptr && !is_word);
  end
endmodule

// File: rtl/bmdma_cmd.sv
module bmdma_cmd
  import bmdma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wdata,
  input  logic       done,
  output logic       go,
  output logic       dir,
  output logic       start_p,
  output logic       abort_p
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go      <= 1'b0;
      dir     <= 1'b0;
      start_p <= 1'b0;
      abort_p <= 1'b0;
    end else begin
      start_p <= 1'b0;
      abort_p <= 1'b0;
      if (done) begin
        go <= 1'b0;
      end else if (wr) begin
        go <= wdata[CMD_GO];
        if (!go) dir <= wdata[CMD_DIR];
        if (wdata[CMD_GO] && !go) start_p <= 1'b1;
        if (!wdata[CMD_GO] && go) abort_p <= 1'b1;
      end
    end
  end

  // R7: direction frozen while a transfer runs
  p_dir_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> $stable(dir));
  // R11: completion returns the channel to idle
  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !go);
  // R13: no request pulse follows a completion cycle
  p_done_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !start_p && !abort_p);
endmodule

// File: rtl/bmdma_stat.sv
module bmdma_stat
  import bmdma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wdata,
  input  logic       act_set,
  input  logic       act_clr,
  input  logic       done,
  output logic [7:0] stat
);
  logic act, err, intr;
  logic [1:0] cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act  <= 1'b0;
      err  <= 1'b0;
      intr <= 1'b0;
      cap  <= 2'b11;
    end else begin
      if (act_clr)      act <= 1'b0;
      else if (act_set) act <= 1'b1;
      if (done)                       intr <= 1'b1;
      else if (wr && wdata[ST_INT])   intr <= 1'b0;
      if (wr && wdata[ST_ERR])        err  <= 1'b0;
      if (wr)                         cap  <= wdata[ST_CAPH:ST_CAPL];
    end
  end

  always_comb begin
    stat = '0;
    stat[ST_ACT] = act;
    stat[ST_ERR] = err;
    stat[ST_INT] = intr;
    stat[ST_CAPH:ST_CAPL] = cap;
  end

  // R12: completion beats a same-cycle acknowledge
  p_done_sets_int_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> intr);
  // R8: a status write alone never moves the active flag
  p_act_ro_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !act_set && !act_clr) |=> (act == $past(act)));
endmodule

// File: rtl/bmdma_chan_regs.sv
module bmdma_chan_regs
  import bmdma_pkg::*;
#(
  parameter int PTR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [2:0]        acc_addr,
  input  logic [1:0]        acc_size,
  input  logic [31:0]       acc_wdata,
  output logic [31:0]       acc_rdata,
  output logic              acc_size_err,
  output logic              dma_start,
  output logic              dma_abort,
  output logic [PTR_W-1:0]  dma_desc_ptr,
  input  logic              dma_done,
  output logic              irq
);
  localparam int IMG_W = 8 * (1 << ADDR_W);

  logic wr_cmd, wr_stat, wr_ptr, size_bad;
  logic go, dir, act_set, act_clr;
  logic [7:0] stat, cmd;
  logic [PTR_W-1:0] ptr_q;
  logic [IMG_W-1:0] image, shifted;

  bmdma_decode u_dec (
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
    .acc_size(acc_size), .wr_cmd(wr_cmd), .wr_stat(wr_stat),
    .wr_ptr(wr_ptr), .size_bad(size_bad)
  );

  bmdma_cmd u_cmd (
    .clk(clk), .rst_n(rst_n), .wr(wr_cmd), .wdata(acc_wdata[7:0]),
    .done(dma_done), .go(go), .dir(dir),
    .start_p(dma_start), .abort_p(dma_abort)
  );

  always_comb begin
    act_set = wr_cmd && !dma_done && acc_wdata[CMD_GO] && !go;
    act_clr = dma_done || (wr_cmd && !acc_wdata[CMD_GO] && go);
  end

  bmdma_stat u_stat (
    .clk(clk), .rst_n(rst_n), .wr(wr_stat), .wdata(acc_wdata[7:0]),
    .act_set(act_set), .act_clr(act_clr), .done(dma_done), .stat(stat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q        <= '0;
      acc_size_err <= 1'b0;
    end else begin
      acc_size_err <= size_bad;
      if (wr_ptr) ptr_q <= {acc_wdata[PTR_W-1:2], 2'b00};
    end
  end

  always_comb begin
    cmd = '0;
    cmd[CMD_GO]  = go;
    cmd[CMD_DIR] = dir;
    image   = {ptr_q, 8'h00, stat, 8'h00, cmd};
    shifted = image >> {acc_addr, 3'b000};
    case (acc_size)
      SZ_BYTE: acc_rdata = {24'h0, shifted[7:0]};
      SZ_HALF: acc_rdata = {16'h0, shifted[15:0]};
      SZ_WORD: acc_rdata = shifted[31:0];
      default: acc_rdata = '0;
    endcase
    dma_desc_ptr = ptr_q;
    irq          = stat[ST_INT];
  end

  // R8 / R4: active flag and go bit always agree
  p_act_go_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stat[ST_ACT] == go);
  // R4: launch pulse only with the channel running
  p_start_running_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dma_start |-> (go && stat[ST_ACT]));
  // R5: abort pulse only with the channel idle
  p_abort_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dma_abort |-> !stat[ST_ACT]);
  // R3: rejected write leaves the pointer alone
  p_bad_size_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_size_err |-> $stable(ptr_q));
  // R10: stored pointer is dword aligned
  p_ptr_align_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q[1:0] == 2'b00);
endmodule

// File: tb/bmdma_chan_regs_test.sv
module bmdma_chan_regs_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic acc_valid = 0, acc_write = 0, dma_done = 0;
  logic [2:0] acc_addr = 0;
  logic [1:0] acc_size = 0;
  logic [31:0] acc_wdata = 0, acc_rdata, dma_desc_ptr;
  logic acc_size_err, dma_start, dma_abort, irq;

  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  bmdma_chan_regs uut (.*);

  // behavioural reference model
  bit m_go, m_dir, m_act, m_err, m_int, m_sp, m_ap, m_se;
  bit [1:0] m_cap;
  bit [31:0] m_ptr;
  bit old_go;

  always @(posedge clk) begin
    m_sp = 0; m_ap = 0; m_se = 0;
    if (!rst_n) begin
      m_go = 0; m_dir = 0; m_act = 0; m_err = 0; m_int = 0; m_cap = 2'b11; m_ptr = 0;
    end else begin
      if (acc_valid && acc_write) begin
        if (acc_addr == 0) begin
          if (acc_size != 0) m_se = 1;
          else if (!dma_done) begin
            old_go = m_go;
            m_go = acc_wdata[0];
            if (!old_go) m_dir = acc_wdata[3];
            if (m_go && !old_go) begin m_sp = 1; m_act = 1; end
            if (!m_go && old_go) begin m_ap = 1; m_act = 0; end
          end
        end else if (acc_addr == 2) begin
          if (acc_size != 0) m_se = 1;
          else begin
            if (acc_wdata[2]) m_int = 0;
            if (acc_wdata[1]) m_err = 0;
            m_cap = acc_wdata[6:5];
          end
        end else if (acc_addr == 4) begin
          if (acc_size != 2) m_se = 1;
          else m_ptr = acc_wdata & 32'hFFFF_FFFC;
        end
      end
      if (dma_done) begin m_go = 0; m_act = 0; m_int = 1; end
    end
  end

  function automatic bit [31:0] m_read(bit [2:0] a, bit [1:0] s);
    bit [63:0] img = {m_ptr, 8'h00, 1'b0, m_cap, 2'b00, m_int, m_err, m_act,
                      8'h00, 4'h0, m_dir, 2'b00, m_go};
    bit [63:0] sh = img >> (8 * a);
    case (s)
      2'd0: return {24'h0, sh[7:0]};
      2'd1: return {16'h0, sh[15:0]};
      2'd2: return sh[31:0];
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison of all registered outputs
  always @(negedge clk) if (rst_n) begin
    chk("R12 irq", irq, m_int);
    chk("R4 dma_start", dma_start, m_sp);
    chk("R5 dma_abort", dma_abort, m_ap);
    chk("R3 acc_size_err", acc_size_err, m_se);
    chk("R10 dma_desc_ptr", dma_desc_ptr, m_ptr);
  end

  task automatic wr(bit [2:0] a, bit [1:0] s, bit [31:0] d, bit done = 0);
    @(negedge clk);
    acc_valid = 1; acc_write = 1; acc_addr = a; acc_size = s; acc_wdata = d; dma_done = done;
    @(negedge clk);
    acc_valid = 0; acc_write = 0; dma_done = 0;
  endtask

  task automatic rd(string req, bit [2:0] a, bit [1:0] s, bit [31:0] exp);
    @(negedge clk);
    acc_valid = 1; acc_write = 0; acc_addr = a; acc_size = s;
    #1;
    chk(req, acc_rdata, m_read(a, s));
    chk(req, acc_rdata, exp);
    acc_valid = 0;
  endtask

  task automatic done_pulse();
    @(negedge clk); dma_done = 1;
    @(negedge clk); dma_done = 0;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd("R1 status", 3'd2, 2'd0, 32'h60);
    rd("R1 command", 3'd0, 2'd0, 32'h0);
    rd("R1 pointer", 3'd4, 2'd2, 32'h0);
    chk("R1 irq", irq, 1'b0);
    // R10 alignment, R2 read sizes
    wr(3'd4, 2'd2, 32'h1234_5677);
    rd("R10 pointer", 3'd4, 2'd2, 32'h1234_5674);
    rd("R2 half", 3'd6, 2'd1, 32'h1234);
    rd("R2 byte", 3'd5, 2'd0, 32'h56);
    rd("R2 word lo", 3'd0, 2'd2, 32'h0060_0000);
    rd("R2 reserved", 3'd1, 2'd0, 32'h0);
    rd("R2 past end", 3'd6, 2'd2, 32'h1234);
    rd("R2 size3", 3'd4, 2'd3, 32'h0);
    // R3 illegal sizes
    wr(3'd4, 2'd0, 32'hFFFF_FFFF);
    rd("R3 ptr kept", 3'd4, 2'd2, 32'h1234_5674);
    wr(3'd0, 2'd1, 32'h0000_0001);
    rd("R3 cmd kept", 3'd0, 2'd0, 32'h0);
    wr(3'd2, 2'd2, 32'h0000_0000);
    rd("R3 stat kept", 3'd2, 2'd0, 32'h60);
    // R4 start with direction set
    wr(3'd0, 2'd0, 32'h09);
    rd("R4 active", 3'd2, 2'd0, 32'h61);
    rd("R7 cmd", 3'd0, 2'd0, 32'h09);
    // R6 / R7 go unchanged, direction held
    wr(3'd0, 2'd0, 32'h01);
    rd("R7 dir held", 3'd0, 2'd0, 32'h09);
    // R8 active read-only, R9 capability bits writable
    wr(3'd2, 2'd0, 32'h00);
    rd("R8 act kept", 3'd2, 2'd0, 32'h01);
    wr(3'd2, 2'd0, 32'hFF);
    rd("R9 reserved bits", 3'd2, 2'd0, 32'h61);
    // R5 abort
    wr(3'd0, 2'd0, 32'h00);
    rd("R5 idle", 3'd2, 2'd0, 32'h60);
    wr(3'd0, 2'd0, 32'h00);
    rd("R7 dir free", 3'd0, 2'd0, 32'h00);
    // R11 completion
    wr(3'd0, 2'd0, 32'h01);
    done_pulse();
    rd("R11 status", 3'd2, 2'd0, 32'h64);
    rd("R11 command", 3'd0, 2'd0, 32'h00);
    chk("R12 irq set", irq, 1'b1);
    // R9 write-one-to-clear
    wr(3'd2, 2'd0, 32'h60);
    rd("R9 zero keeps", 3'd2, 2'd0, 32'h64);
    wr(3'd2, 2'd0, 32'h64);
    rd("R9 int cleared", 3'd2, 2'd0, 32'h60);
    wr(3'd2, 2'd0, 32'h66);
    rd("R9 one on zero", 3'd2, 2'd0, 32'h60);
    // R12 completion collides with acknowledge
    wr(3'd0, 2'd0, 32'h01);
    wr(3'd2, 2'd0, 32'h64, 1'b1);
    rd("R12 int kept", 3'd2, 2'd0, 32'h64);
    wr(3'd2, 2'd0, 32'h64);
    // R13 completion collides with command writes
    wr(3'd0, 2'd0, 32'h01);
    wr(3'd0, 2'd0, 32'h00, 1'b1);
    rd("R13 stop ignored", 3'd0, 2'd0, 32'h00);
    wr(3'd0, 2'd0, 32'h09, 1'b1);
    rd("R13 start ignored", 3'd0, 2'd0, 32'h00);
    rd("R13 status", 3'd2, 2'd0, 32'h64);
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule